// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block sits on the host side of an external flash device. After the host has sent a program or erase command sequence, it pulses `start`. The block then works out when the embedded operation has ended and whether it succeeded. It fetches status words through a read request/valid handshake. It compares the toggle bit across back-to-back reads and watches the timeout-flag bit.

A stable toggle bit across a fresh pair of reads means the operation is complete. If the bit is still toggling while the timeout flag is low, the block starts a new pair of reads from scratch. If the bit is still toggling while the timeout flag is high, the block makes one more pair of reads. This guards against the toggle stopping at the same moment the flag rises. If that confirmation pair still toggles, the operation failed. On any failure the block sends one reset-command write through a request/acknowledge handshake, which returns the device to array-read mode.

A counter of polling pairs acts as a watchdog and forces a failure when the pair count passes a limit. An abort input lets the host leave polling at any point before the reset write. After an abort, the next `start` begins again at the first read of a pair.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset `busy`, `done`, `fail`, `rd_req` and `cmd_req` are all low.
- R2: A `start` pulse while idle raises `busy` on the next clock and asserts `rd_req`. Each `rd_req` stays high until a cycle in which `rd_vld` is high, and that cycle completes the read. The toggle bit is `rd_data[TOG_BIT]` (default bit 6) and the timeout flag is `rd_data[TMO_BIT]` (default bit 5).
- R3: If the toggle bit has the same value in both reads of the first pair, the block finishes with `done` high after exactly two reads and issues no command write.
- R4: If the toggle bit differs within a pair while the timeout flag of the second read is 0, the block starts a new pair. The first read of the new pair becomes the new reference.
- R5: If the toggle bit differs within a pair while the timeout flag of the second read is 1, the block makes one confirmation pair. An equal toggle bit in that pair gives `done` with no command write.
- R6: If the toggle bit still differs in the confirmation pair, the result is a failure.
- R7: On any failure `cmd_req` is held high until `cmd_ack`. Exactly one write is accepted. `fail` rises on the clock after that acceptance, and `busy` stays high until then.
- R8: If MAX_POLLS ordinary pairs in a row all toggle with the timeout flag 0, the block takes the failure path of R7 after the last of them. A fresh `start` clears the pair count.
- R9: `abort` while busy and not writing the reset command returns the block to idle on the next clock. It produces no `done`, no `fail` and no command write. The next `start` again needs a full fresh pair.
- R10: `done` and `fail` are never high together and are low while busy. A result stays high until the next `start`. Status bits other than the toggle bit and the timeout flag have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin polling (sampled while idle) |
| abort | input | 1 | Leave polling without a result |
| rd_req | output | 1 | Status read request |
| rd_vld | input | 1 | Status read data valid; completes a read |
| rd_data | input | DATA_W | Status word returned by the read |
| cmd_req | output | 1 | Reset-command write request |
| cmd_ack | input | 1 | Reset-command write accepted |
| busy | output | 1 | Polling or reset write in progress |
| done | output | 1 | Operation finished successfully |
| fail | output | 1 | Operation failed (after reset write) |

## Verification
The bench covers the case where the toggle stops exactly when the timeout flag rises. A design that skipped the confirmation pair would report a failure there, or would report success without the extra reads. It also feeds a confirmation pair that keeps toggling, which a design that forgot the reset write would finish with no acknowledge handshake at all. A design that kept the old reference bit across a new pair would show up on the DQ5-low loop pattern. The same design, after an abort, would accept a single read as a finished pair and give the wrong read count. An endless toggling pattern shows whether the watchdog fires after exactly the configured pair count, and a following run shows whether that count restarts.

// File: rtl/toggle_poll_pkg.sv
// Shared types for the toggle-bit completion poller.
// Assumes nothing beyond a synthesizable enum encoding.
package toggle_poll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for start
        ST_RD1  = 3'd1,   // first read of an ordinary pair
        ST_RD2  = 3'd2,   // second read of an ordinary pair
        ST_CF1  = 3'd3,   // first read of the confirmation pair
        ST_CF2  = 3'd4,   // second read of the confirmation pair
        ST_CMD  = 3'd5    // reset-command write
    } poll_state_t;

endpackage

// File: rtl/poll_bit_sampler.sv
// Holds the toggle bit of the first read of a pair and reports whether the
// current read differs from it. Assumes the caller pulses cap on the
// accepted first read of every pair, so a new pair never uses an old reference.
module poll_bit_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic cap,
    input  logic tog_in,
    input  logic tmo_in,
    output logic toggled,
    output logic timed_out
);

    logic ref_bit;

    // Capture the reference toggle bit on the first read of a pair.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_bit <= 1'b0;
        else if (cap)
            ref_bit <= tog_in;
    end

    // Compare the current read against the stored reference.
    always_comb begin
        toggled   = tog_in ^ ref_bit;
        timed_out = tmo_in;
    end

endmodule

// File: rtl/poll_watchdog.sv
// Counts ordinary polling pairs that ended still toggling. at_limit is high
// when the pair now ending is the MAX_POLLS-th one. MAX_POLLS of 0 turns
// the watchdog off. Assumes clr and inc never coincide.
module poll_watchdog #(
    parameter int MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);

    localparam int CNT_W = $clog2(MAX_POLLS + 2);

    generate
        if (MAX_POLLS == 0) begin : g_off
            logic unused_wd;
            // Watchdog disabled: inputs are deliberately unused.
            assign unused_wd = clk ^ rst_n ^ clr ^ inc;
            assign at_limit  = 1'b0;
        end else begin : g_on
            logic [CNT_W-1:0] pairs_q;

            // Count completed toggling pairs, cleared at each new start.
            always_ff @(posedge clk) begin
                if (!rst_n || clr)
                    pairs_q <= '0;
                else if (inc)
                    pairs_q <= pairs_q + 1'b1;
            end

            assign at_limit = (pairs_q == CNT_W'(MAX_POLLS - 1));
        end
    endgenerate

endmodule

// File: rtl/poll_fsm.sv
// Sequencing for toggle-bit polling. It runs ordinary read pairs, a
// confirmation pair when the timeout flag is seen, and a reset-command
// write on failure, and it holds the done/fail result.
// Assumes the sampler and watchdog outputs are combinational on this cycle.
module poll_fsm
    import toggle_poll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    input  logic rd_vld,
    input  logic cmd_ack,
    input  logic toggled,
    input  logic timed_out,
    input  logic at_limit,
    output logic rd_req,
    output logic cmd_req,
    output logic cap,
    output logic wd_clr,
    output logic wd_inc,
    output logic busy,
    output logic done,
    output logic fail
);

    poll_state_t state_q, state_d;
    logic        done_q, fail_q;
    logic        acc, set_done, set_fail, launch;

    // Next-state and control decode.
    always_comb begin
        state_d  = state_q;
        set_done = 1'b0;
        set_fail = 1'b0;
        wd_inc   = 1'b0;
        rd_req   = (state_q == ST_RD1) || (state_q == ST_RD2) ||
                   (state_q == ST_CF1) || (state_q == ST_CF2);
        cmd_req  = (state_q == ST_CMD);
        acc      = rd_req && rd_vld;
        launch   = (state_q == ST_IDLE) && start && !abort;
        cap      = acc && !abort && ((state_q == ST_RD1) || (state_q == ST_CF1));
        unique case (state_q)
            ST_IDLE: if (launch) state_d = ST_RD1;
            ST_RD1: begin
                if (abort)    state_d = ST_IDLE;
                else if (acc) state_d = ST_RD2;
            end
            ST_RD2: begin
                if (abort) state_d = ST_IDLE;
                else if (acc) begin
                    if (!toggled) begin
                        state_d  = ST_IDLE;
                        set_done = 1'b1;
                    end else if (timed_out) begin
                        state_d = ST_CF1;
                    end else if (at_limit) begin
                        state_d = ST_CMD;
                    end else begin
                        state_d = ST_RD1;
                        wd_inc  = 1'b1;
                    end
                end
            end
            ST_CF1: begin
                if (abort)    state_d = ST_IDLE;
                else if (acc) state_d = ST_CF2;
            end
            ST_CF2: begin
                if (abort) state_d = ST_IDLE;
                else if (acc) begin
                    if (!toggled) begin
                        state_d  = ST_IDLE;
                        set_done = 1'b1;
                    end else begin
                        state_d = ST_CMD;
                    end
                end
            end
            ST_CMD: begin
                if (cmd_ack) begin
                    state_d  = ST_IDLE;
                    set_fail = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        wd_clr = launch;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result flags: cleared by a new start, set when a run ends.
    always_ff @(posedge clk) begin
        if (!rst_n || launch) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            if (set_done) done_q <= 1'b1;
            if (set_fail) fail_q <= 1'b1;
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;
    assign fail = fail_q;

endmodule

// File: rtl/toggle_poll_ctrl.sv
// Top of the toggle-bit completion poller. It picks the toggle and timeout
// bits out of the status word and wires the sampler, watchdog and FSM.
// Assumes rd_data is valid whenever rd_vld is high.
module toggle_poll_ctrl #(
    parameter int DATA_W    = 8,
    parameter int TOG_BIT   = 6,
    parameter int TMO_BIT   = 5,
    parameter int MAX_POLLS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    output logic              rd_req,
    input  logic              rd_vld,
    input  logic [DATA_W-1:0] rd_data,
    output logic              cmd_req,
    input  logic              cmd_ack,
    output logic              busy,
    output logic              done,
    output logic              fail
);

    logic toggled, timed_out, at_limit, cap, wd_clr, wd_inc;
    logic unused_status;

    // Only the toggle and timeout bits matter; the rest are intentionally dropped.
    assign unused_status = ^rd_data;

    poll_bit_sampler u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (cap),
        .tog_in    (rd_data[TOG_BIT]),
        .tmo_in    (rd_data[TMO_BIT]),
        .toggled   (toggled),
        .timed_out (timed_out)
    );

    poll_watchdog #(.MAX_POLLS(MAX_POLLS)) u_wd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (wd_clr),
        .inc      (wd_inc),
        .at_limit (at_limit)
    );

    poll_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .abort     (abort),
        .rd_vld    (rd_vld),
        .cmd_ack   (cmd_ack),
        .toggled   (toggled),
        .timed_out (timed_out),
        .at_limit  (at_limit),
        .rd_req    (rd_req),
        .cmd_req   (cmd_req),
        .cap       (cap),
        .wd_clr    (wd_clr),
        .wd_inc    (wd_inc),
        .busy      (busy),
        .done      (done),
        .fail      (fail)
    );

endmodule

// File: rtl/toggle_poll_checker.sv
// Protocol and result checks for toggle_poll_ctrl, attached through bind.
// Assumes the port names of the top module.
module toggle_poll_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic abort,
    input logic rd_req,
    input logic rd_vld,
    input logic cmd_req,
    input logic cmd_ack,
    input logic busy,
    input logic done,
    input logic fail
);

    assert_result_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    assert_no_result_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done && !fail);

    assert_read_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_vld && !abort |=> rd_req);

    assert_cmd_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && !cmd_ack |=> cmd_req);

    assert_fail_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $past(cmd_req && cmd_ack));

    assert_one_request_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && cmd_req));

    assert_abort_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort && busy && !cmd_req |=> !busy && !done && !fail);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start && !abort && !busy |=> busy && rd_req);

endmodule

bind toggle_poll_ctrl toggle_poll_checker u_chk (.*);

// File: tb/tb_toggle_poll_ctrl.sv
module tb_toggle_poll_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, abort = 1'b0;
    logic rd_req, rd_vld = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic cmd_req, cmd_ack = 1'b0;
    logic busy, done, fail;

    int n_tests = 0, n_fail = 0;
    logic [7:0] q [8];
    int q_len = 0, q_idx = 0, reads = 0, cmds = 0;

    // Status bytes: toggle bit is bit 6, timeout flag is bit 5.
    localparam logic [47:0] V_BYTES [NV] = '{
        48'h4040_0000_0000,  // stable high
        48'h0000_0000_0000,  // stable low
        48'h4000_0000_0000,  // toggle, flag low, then stable
        48'h4020_6060_0000,  // toggle with flag, confirm stable
        48'h4020_6020_0000,  // toggle with flag, confirm toggles
        48'h0444_4444_0000,  // other bit changes, toggle bit too
        48'h2020_0000_0000   // flag high but not toggling
    };
    localparam int V_LEN   [NV] = '{2, 2, 4, 4, 4, 4, 2};
    localparam int V_DONE  [NV] = '{1, 1, 1, 1, 0, 1, 1};
    localparam int V_CMDS  [NV] = '{0, 0, 0, 0, 1, 0, 0};
    localparam int V_REQ   [NV] = '{3, 3, 4, 5, 6, 4, 10};

    toggle_poll_ctrl #(.MAX_POLLS(4)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .rd_req(rd_req), .rd_vld(rd_vld), .rd_data(rd_data),
        .cmd_req(cmd_req), .cmd_ack(cmd_ack),
        .busy(busy), .done(done), .fail(fail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Flash model: answers reads and command writes at the falling edge.
    always @(negedge clk) begin
        if (rd_req && !rd_vld) begin
            rd_vld  <= 1'b1;
            rd_data <= (q_idx < q_len) ? q[q_idx] : (q_idx[0] ? 8'h00 : 8'h40);
        end else begin
            rd_vld <= 1'b0;
        end
        cmd_ack <= cmd_req && !cmd_ack;
    end

    // Transfer counters at the active edge.
    always @(posedge clk) begin
        if (rd_req && rd_vld) begin reads <= reads + 1; q_idx <= q_idx + 1; end
        if (cmd_req && cmd_ack) cmds <= cmds + 1;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [47:0] b, input int len);
        @(negedge clk);
        for (int i = 0; i < 6; i++) q[i] = b[47-8*i -: 8];
        q_len = len; q_idx = 0; reads = 0; cmds = 0;
    endtask

    task automatic run_to_idle();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "fail", fail, 0);
        check("R1", "rd_req", rd_req, 0);
        check("R1", "cmd_req", cmd_req, 0);

        // Table walk: R3 R4 R5 R6 R7 R10.
        for (int v = 0; v < NV; v++) begin
            load(V_BYTES[v], V_LEN[v]);
            run_to_idle();
            check($sformatf("R%0d", V_REQ[v]), $sformatf("vec%0d done", v), done, V_DONE[v]);
            check($sformatf("R%0d", V_REQ[v]), $sformatf("vec%0d fail", v), fail, 1 - V_DONE[v]);
            check("R2", $sformatf("vec%0d reads", v), reads, V_LEN[v]);
            check("R7", $sformatf("vec%0d cmds", v), cmds, V_CMDS[v]);
        end

        // R10: result held until next start.
        repeat (3) @(negedge clk);
        check("R10", "done held", done, 1);

        // R8: endless toggling with flag low, watchdog after 4 pairs.
        load(48'h0, 0);
        run_to_idle();
        check("R8", "fail", fail, 1);
        check("R8", "reads", reads, 8);
        check("R8", "cmds", cmds, 1);
        // R8: count restarts with a new start.
        load(48'h4000_4000_4000, 6);
        run_to_idle();
        check("R8", "fail after restart", fail, 1);
        check("R8", "reads after restart", reads, 8);

        // R9: abort mid-poll, then a fresh start needs a full pair.
        load(48'h0, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check("R9", "busy", busy, 0);
        check("R9", "done", done, 0);
        check("R9", "fail", fail, 0);
        check("R9", "cmds", cmds, 0);
        load(48'h4040_0000_0000, 2);
        run_to_idle();
        check("R9", "done after restart", done, 1);
        check("R9", "reads after restart", reads, 2);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule